// File: doc/BRIEF.md
# Line Access Switch Control Logic

This block is the digital control core of a six-pole telephone line access switch. It drives three switch-group enables: break (line to subscriber circuit), ringing (line to ring generator) and test (line to test bus). Two mode inputs, ring and test, choose the state. An active-low enable input, holdN, lets new mode values through when low. When holdN is high, the present switch state is frozen. Three fault flags override everything: an active-low thermal shutdown, a supply-valid flag and a battery-present flag.

A sticky lockout holds all switches off from reset, and again after any loss of supply or battery. It stays in force until holdN is seen low while supply and battery are both good. A floating enable line is therefore safe on hot insertion. The sync stages for holdN reset to the inactive (high) level, so an enable that has never been driven low keeps the lockout in place.

A parameter selects the decode variant. The basic variant maps mode 11 to all-off. The extended variant allows combined test-with-talk and test-with-ringing states.

Top module: `line_access_ctrl`

## Requirements
- R1: After reset all three enables are off (stateCode 3'b000). They stay off while holdN remains high, even with supply, battery and shutdown all good.
- R2: Basic variant (EXTENDED=0), stateCode = {break, ring, test}, with holdN low and no fault. Mode {ring,test}=00 gives 3'b100 (talk), 01 gives 3'b001 (test), 10 gives 3'b010 (ringing), 11 gives 3'b000 (all-off).
- R3: Extended variant (EXTENDED=1). Mode 00 gives 3'b100 and 10 gives 3'b010. Mode 01 gives 3'b101 (test with talk). Mode 11 gives 3'b011 (test with ringing).
- R4: While holdN is high, changes on the mode inputs do not change the outputs.
- R5: shutdownN low forces 3'b000 at the next rising edge, whatever holdN and the mode are. It does not set the lockout. After release with holdN high, the outputs keep the all-off value they last held.
- R6: supplyOk low forces 3'b000 at the next rising edge. The mode inputs and holdN are ignored while it stays low.
- R7: After supplyOk returns, the outputs stay 3'b000 until holdN is seen low. If holdN is already low and settled, the mode state appears at the second rising edge after supplyOk returns. If holdN is driven low later, the mode state appears at the fourth rising edge after that change.
- R8: batteryOk low forces 3'b000 at the next rising edge and sets the same lockout as R6.
- R9: With holdN low and no fault, a mode change reaches the outputs at the third rising edge after it is applied (two sync stages plus the output register).
- R10: breakEn, ringEn and testEn always equal stateCode bits 2, 1 and 0. Break and ringing are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ringIn | input | 1 | Mode select, ring bit (asynchronous) |
| testIn | input | 1 | Mode select, test bit (asynchronous) |
| holdN | input | 1 | Input enable, active low; high freezes the state |
| shutdownN | input | 1 | Thermal shutdown, active low |
| supplyOk | input | 1 | Supply valid flag |
| batteryOk | input | 1 | Battery present flag |
| breakEn | output | 1 | Break switch group enable |
| ringEn | output | 1 | Ringing switch group enable |
| testEn | output | 1 | Test switch group enable |
| stateCode | output | 3 | {break, ring, test} status |

## Verification
The assertions assume that the three fault flags are already synchronous to clk, since they act at the very next edge. The hold property also assumes that holdN is stable for three samples before freezing is expected. The bench changes every input only on the falling edge. It keeps each flag level for at least one full cycle and lets holdN settle for three or more cycles before it checks a frozen or released state. Two instances, one per variant, share the stimulus. A behavioural model with queued input history is compared with both on every cycle.

// File: rtl/line_access_pkg.sv
package line_access_pkg;
  typedef struct packed {
    logic forceOff;
    logic load;
  } swStrobe_t;

  typedef struct packed {
    logic breakOn;
    logic ringOn;
    logic testOn;
  } swState_t;
endpackage

// File: rtl/la_sync.sv
module la_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/la_ctrl.sv
module la_ctrl
  import line_access_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      holdS,
  input  logic      shutdownN,
  input  logic      supplyOk,
  input  logic      batteryOk,
  output swStrobe_t strobe
);
  logic lockout;
  logic powerBad;

  assign powerBad = !supplyOk || !batteryOk;

  // sticky lockout: armed by reset or power loss, released by a seen enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         lockout <= 1'b1;
    else if (powerBad) lockout <= 1'b1;
    else if (!holdS)   lockout <= 1'b0;
  end

  always_comb begin
    strobe.forceOff = lockout || powerBad || !shutdownN;
    strobe.load     = !holdS;
  end
endmodule

// File: rtl/la_datapath.sv
module la_datapath
  import line_access_pkg::*;
#(
  parameter bit EXTENDED = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  swStrobe_t strobe,
  input  logic      ringS,
  input  logic      testS,
  output swState_t  state
);
  swState_t nextState;

  generate
    if (EXTENDED) begin : g_ext
      always_comb begin
        nextState.breakOn = !ringS;
        nextState.ringOn  = ringS;
        nextState.testOn  = testS;
      end
    end else begin : g_basic
      always_comb begin
        unique case ({ringS, testS})
          2'b00:   nextState = '{breakOn: 1'b1, ringOn: 1'b0, testOn: 1'b0};
          2'b01:   nextState = '{breakOn: 1'b0, ringOn: 1'b0, testOn: 1'b1};
          2'b10:   nextState = '{breakOn: 1'b0, ringOn: 1'b1, testOn: 1'b0};
          default: nextState = '0;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                state <= '0;
    else if (strobe.forceOff) state <= '0;
    else if (strobe.load)     state <= nextState;
  end
endmodule

// File: rtl/line_access_ctrl.sv
module line_access_ctrl
  import line_access_pkg::*;
#(
  parameter bit EXTENDED = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ringIn,
  input  logic       testIn,
  input  logic       holdN,
  input  logic       shutdownN,
  input  logic       supplyOk,
  input  logic       batteryOk,
  output logic       breakEn,
  output logic       ringEn,
  output logic       testEn,
  output logic [2:0] stateCode
);
  localparam int SYNC_W = 3;
  localparam logic [SYNC_W-1:0] SYNC_RST = 3'b001;

  logic [SYNC_W-1:0] syncOut;
  swStrobe_t strobe;
  swState_t  state;

  la_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN), .d({ringIn, testIn, holdN}), .q(syncOut)
  );

  la_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .holdS(syncOut[0]), .shutdownN(shutdownN),
    .supplyOk(supplyOk), .batteryOk(batteryOk), .strobe(strobe)
  );

  la_datapath #(.EXTENDED(EXTENDED)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ringS(syncOut[2]), .testS(syncOut[1]), .state(state)
  );

  assign breakEn   = state.breakOn;
  assign ringEn    = state.ringOn;
  assign testEn    = state.testOn;
  assign stateCode = {state.breakOn, state.ringOn, state.testOn};
endmodule

// File: rtl/line_access_chk.sv
module line_access_chk #(
  parameter bit EXTENDED = 1'b0
) (
  input logic       clk,
  input logic       rstN,
  input logic       holdN,
  input logic       shutdownN,
  input logic       supplyOk,
  input logic       batteryOk,
  input logic       breakEn,
  input logic       ringEn,
  input logic       testEn,
  input logic [2:0] stateCode
);
  // R5
  shutdown_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shutdownN |=> stateCode == 3'b000);

  // R6
  supply_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> stateCode == 3'b000);

  // R8
  battery_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !batteryOk |=> stateCode == 3'b000);

  // R7
  supply_return_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(supplyOk) |=> stateCode == 3'b000);

  // R4
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdN && $past(holdN) && $past(holdN, 2)) |=> ($stable(stateCode) || stateCode == 3'b000));

  // R10
  no_break_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(breakEn && ringEn));

  // R2
  basic_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !EXTENDED |-> $countones({breakEn, ringEn, testEn}) <= 1);
endmodule

bind line_access_ctrl line_access_chk #(.EXTENDED(EXTENDED)) u_chk (
  .clk(clk), .rstN(rstN), .holdN(holdN), .shutdownN(shutdownN),
  .supplyOk(supplyOk), .batteryOk(batteryOk), .breakEn(breakEn),
  .ringEn(ringEn), .testEn(testEn), .stateCode(stateCode)
);

// File: tb/line_access_ctrl_bench.sv
`timescale 1ns/1ps
module line_access_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ringIn = 1'b0, testIn = 1'b0, holdN = 1'b1;
  logic shutdownN = 1'b1, supplyOk = 1'b1, batteryOk = 1'b1;
  logic breakB, ringB, testB, breakE, ringE, testE;
  logic [2:0] codeB, codeE;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  string curReq = "R1";

  always #10 clk = ~clk;

  line_access_ctrl #(.EXTENDED(1'b0)) u_line_access_ctrl (
    .clk(clk), .rstN(rstN), .ringIn(ringIn), .testIn(testIn), .holdN(holdN),
    .shutdownN(shutdownN), .supplyOk(supplyOk), .batteryOk(batteryOk),
    .breakEn(breakB), .ringEn(ringB), .testEn(testB), .stateCode(codeB)
  );

  line_access_ctrl #(.EXTENDED(1'b1)) u_line_access_ctrl_ext (
    .clk(clk), .rstN(rstN), .ringIn(ringIn), .testIn(testIn), .holdN(holdN),
    .shutdownN(shutdownN), .supplyOk(supplyOk), .batteryOk(batteryOk),
    .breakEn(breakE), .ringEn(ringE), .testEn(testE), .stateCode(codeE)
  );

  // behavioural reference
  bit qR[$], qT[$], qH[$];
  bit lockM;
  logic [2:0] mB = 3'b000, mE = 3'b000;

  function automatic logic [2:0] basicRow(bit r, bit t);
    case ({r, t})
      2'b00: return 3'b100;
      2'b01: return 3'b001;
      2'b10: return 3'b010;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] extRow(bit r, bit t);
    case ({r, t})
      2'b00: return 3'b100;
      2'b01: return 3'b101;
      2'b10: return 3'b010;
      default: return 3'b011;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      qR = '{1'b0, 1'b0}; qT = '{1'b0, 1'b0}; qH = '{1'b1, 1'b1};
      lockM = 1'b1; mB = 3'b000; mE = 3'b000;
    end else begin
      bit r, t, h;
      r = qR[0]; t = qT[0]; h = qH[0];
      if (!supplyOk || !batteryOk || !shutdownN || lockM) begin
        mB = 3'b000; mE = 3'b000;
      end else if (!h) begin
        mB = basicRow(r, t); mE = extRow(r, t);
      end
      if (!supplyOk || !batteryOk) lockM = 1'b1;
      else if (!h) lockM = 1'b0;
      void'(qR.pop_front()); void'(qT.pop_front()); void'(qH.pop_front());
      qR.push_back(ringIn); qT.push_back(testIn); qH.push_back(holdN);
    end
  end

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model, plus R10 pin consistency
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk({curReq, " basic model"}, codeB, mB);
      chk({curReq, " ext model"}, codeE, mE);
      chk("R10 pins basic", {breakB, ringB, testB}, codeB);
      chk("R10 pins ext", {breakE, ringE, testE}, codeE);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setMode(bit r, bit t);
    ringIn = r; testIn = t;
  endtask

  initial begin
    waitN(3);
    rstN = 1'b1;
    // R1: lockout after reset with enable high
    curReq = "R1";
    waitN(6);
    chk("R1 reset all-off basic", codeB, 3'b000);
    chk("R1 reset all-off ext", codeE, 3'b000);

    // R2 / R3 truth rows
    curReq = "R2";
    holdN = 1'b0; setMode(0, 0);
    waitN(5);
    chk("R2 talk basic", codeB, 3'b100);
    chk("R3 talk ext", codeE, 3'b100);
    setMode(0, 1); waitN(4);
    chk("R2 test basic", codeB, 3'b001);
    chk("R3 test-talk ext", codeE, 3'b101);
    setMode(1, 0); waitN(4);
    chk("R2 ringing basic", codeB, 3'b010);
    chk("R3 ringing ext", codeE, 3'b010);
    curReq = "R3";
    setMode(1, 1); waitN(4);
    chk("R2 all-off basic", codeB, 3'b000);
    chk("R3 test-ring ext", codeE, 3'b011);

    // R9 latency
    curReq = "R9";
    setMode(0, 0); waitN(4);
    setMode(1, 0);
    waitN(1); chk("R9 edge1 unchanged", codeB, 3'b100);
    waitN(1); chk("R9 edge2 unchanged", codeB, 3'b100);
    waitN(1); chk("R9 edge3 updated", codeB, 3'b010);

    // R4 hold
    curReq = "R4";
    holdN = 1'b1; waitN(4);
    setMode(0, 1); waitN(3);
    setMode(0, 0); waitN(3);
    chk("R4 hold basic", codeB, 3'b010);
    chk("R4 hold ext", codeE, 3'b010);

    // R5 shutdown
    curReq = "R5";
    shutdownN = 1'b0;
    waitN(1);
    chk("R5 shutdown basic", codeB, 3'b000);
    chk("R5 shutdown ext", codeE, 3'b000);
    shutdownN = 1'b1; waitN(4);
    chk("R5 stays off with hold high", codeB, 3'b000);
    holdN = 1'b0; waitN(4);
    chk("R5 resumes without lockout", codeB, 3'b100);

    // R6 supply loss, inputs ignored
    curReq = "R6";
    supplyOk = 1'b0;
    waitN(1);
    chk("R6 supply loss off", codeB, 3'b000);
    setMode(0, 1); waitN(2);
    setMode(1, 1); holdN = 1'b1; waitN(2);
    holdN = 1'b0; setMode(1, 0); waitN(4);
    chk("R6 inputs ignored basic", codeB, 3'b000);
    chk("R6 inputs ignored ext", codeE, 3'b000);

    // R7 return with enable already low
    curReq = "R7";
    setMode(0, 0); waitN(3);
    supplyOk = 1'b1;
    waitN(1); chk("R7 edge1 still off", codeB, 3'b000);
    waitN(1); chk("R7 edge2 follows mode", codeB, 3'b100);

    // R7 return with enable high: lockout held
    supplyOk = 1'b0; waitN(2);
    holdN = 1'b1; waitN(4);
    supplyOk = 1'b1; waitN(8);
    chk("R7 lockout holds basic", codeB, 3'b000);
    chk("R7 lockout holds ext", codeE, 3'b000);
    holdN = 1'b0;
    waitN(3); chk("R7 edge3 still locked", codeB, 3'b000);
    waitN(1); chk("R7 edge4 released", codeB, 3'b100);

    // R8 battery loss sets lockout
    curReq = "R8";
    setMode(0, 1); waitN(4);
    chk("R8 before loss ext", codeE, 3'b101);
    batteryOk = 1'b0;
    waitN(1);
    chk("R8 battery loss basic", codeB, 3'b000);
    chk("R8 battery loss ext", codeE, 3'b000);
    holdN = 1'b1; waitN(4);
    batteryOk = 1'b1; waitN(6);
    chk("R8 lockout after battery return", codeE, 3'b000);
    holdN = 1'b0; waitN(5);
    chk("R8 released ext", codeE, 3'b101);
    chk("R8 released basic", codeB, 3'b001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule